// File: doc/BRIEF.md
# Posted-Write Register Bridge to a Gated Timer Domain

This block sits between a bus-clock register file and a timer core that runs on its own clock. It keeps four 16-bit registers on the bus side: counter preset, first compare value, second compare value and timer setup. A bus write finishes as soon as the bus-side copy is updated. After that, a toggle request/acknowledge handshake for that register carries the value into a timer-domain shadow. Two-flop synchronizers cross the handshake in each direction. If the bus reads or writes a register whose earlier value has not yet been acknowledged, the access is stalled until the acknowledge returns.

The timer clock stays off after reset. The first write to the setup register does two things. It enables the timer clock and it latches a clock-source choice, which cannot change after that. Any register written before that first setup write is loaded into the timer in the same timer cycle as the setup value. Two compare outputs from the timer come back into the bus domain through separate synchronizers.

The bus side is a valid/ready request port. A request is taken in a cycle where `bus_valid` and `bus_ready` are both high. `bus_ready` is low only while a stalled register is targeted. Read data is valid in the accepting cycle. A requester may drop a request that has not been accepted. This is the only way out of an access that waits on a clock that never starts.

Top module: `timer_xfer_bridge`

## Requirements
- R1: A 16-bit write (`bus_size` = 2'b10) to an idle register is accepted in the cycle it is presented. It stores `bus_wdata[15:0]` into register `bus_addr` (0 counter, 1 compare 1, 2 compare 2, 3 setup).
- R2: A byte write (`bus_size` = 2'b01 or 2'b00) is accepted at once and changes no register. It starts no transfer.
- R3: A 32-bit write (`bus_size` = 2'b11) picks the register pair {0,1} or {2,3} by `bus_addr[1]`. It writes `bus_wdata[15:0]` to the even register and `bus_wdata[31:16]` to the odd register in the same cycle.
- R4: After a register is written, any access that targets it holds `bus_ready` low until its transfer is acknowledged. Accesses to other registers are not delayed.
- R5: `tmr_clk_en` stays low from reset until the first setup write, and no `tmr_load` strobe occurs before that.
- R6: The first setup write latches setup bit 12 onto `tmr_clk_sel`. Later setup writes leave `tmr_clk_sel` unchanged.
- R7: Registers written before the clock starts are loaded into the timer in the same timer cycle as the first setup value.
- R8: Each completed transfer gives exactly one one-cycle `tmr_load` pulse for that register (bit order as R1), with the matching `tmr_*` output holding the new value.
- R9: Each bit of `tmr_cmp_raw` appears on `bus_cmp` after two bus clock edges. The two bits have independent synchronizers.
- R10: If the timer clock never starts, an access to a register with a pending transfer keeps `bus_ready` low indefinitely.
- R11: A read returns the bus-side register in `bus_rdata[15:0]` (upper half zero). A 32-bit read returns the pair as {odd, even}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| tmr_clk | input | 1 | Free-running timer source clock |
| tmr_rst_n | input | 1 | Timer-domain asynchronous reset, active low |
| bus_valid | input | 1 | Access request |
| bus_ready | output | 1 | Request can be taken this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | 01/00 byte, 10 word, 11 doubleword |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while accepted |
| bus_cmp | output | 2 | Synchronized compare outputs |
| tmr_clk_en | output | 1 | Timer clock enable (one-shot switch) |
| tmr_clk_sel | output | 1 | Locked clock-source choice |
| tmr_count | output | 16 | Counter preset in the timer domain |
| tmr_cmp1 | output | 16 | Compare 1 value in the timer domain |
| tmr_cmp2 | output | 16 | Compare 2 value in the timer domain |
| tmr_setup | output | 16 | Setup value in the timer domain |
| tmr_load | output | 4 | One-cycle load strobe per register |
| tmr_cmp_raw | input | 2 | Compare outputs from the timer core |

## Verification
The assertions check four things on every cycle:
- a register just written cannot be accepted again in the next cycle;
- a byte write leaves every bus-side register unchanged;
- the clock choice never moves once the switch is armed, and the clock enable stays low until then;
- no load strobe appears while the timer clock is disabled.

Only the bench scenarios show the rest:
- the pre-start hang;
- the joint loading of early writes with the first setup value;
- the stall on a second access until the acknowledge returns;
- the values that arrive in the timer;
- the two-edge latency of each compare synchronizer.

// File: rtl/timer_xfer_pkg.sv
package timer_xfer_pkg;
  localparam int NREG = 4;
  localparam int IDXW = 2;

  typedef enum logic [1:0] {
    SZ_BYTE0 = 2'b00,
    SZ_BYTE  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } acc_size_e;

  typedef enum logic [IDXW-1:0] {
    REG_COUNT = 2'd0,
    REG_CMP1  = 2'd1,
    REG_CMP2  = 2'd2,
    REG_SETUP = 2'd3
  } reg_idx_e;

  function automatic logic is_narrow(input logic [1:0] sz);
    return (sz == SZ_BYTE) || (sz == SZ_BYTE0);
  endfunction

  function automatic logic [NREG-1:0] target_mask(input logic [1:0] sz,
                                                  input logic [IDXW-1:0] ad);
    logic [NREG-1:0] m;
    if (sz == SZ_DWORD) m = NREG'(2'b11) << {ad[1], 1'b0};
    else                m = NREG'(1) << ad;
    return m;
  endfunction
endpackage

// File: rtl/txb_sync.sv
module txb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  stg[s] <= '0;
        else if (en) stg[s] <= (s == 0) ? d : stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/txb_channel.sv
module txb_channel #(
  parameter int DW     = 16,
  parameter int STAGES = 2
) (
  input  logic          bus_clk,
  input  logic          bus_rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] bus_val,
  output logic          busy,
  input  logic          tmr_clk,
  input  logic          tmr_rst_n,
  input  logic          tmr_run,
  output logic [DW-1:0] tmr_val,
  output logic          tmr_load
);
  logic req_q, ack_at_bus, req_at_tmr, ack_q;

  // Bus side: posted store plus request toggle.
  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      bus_val <= '0;
      req_q   <= 1'b0;
    end else if (wr_en) begin
      bus_val <= wr_data;
      req_q   <= ~req_q;
    end
  end

  txb_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .en(1'b1), .d(ack_q), .q(ack_at_bus)
  );

  assign busy = req_q ^ ack_at_bus;

  // Timer side: everything here advances only while the timer clock runs.
  txb_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
    .clk(tmr_clk), .rst_n(tmr_rst_n), .en(tmr_run), .d(req_q), .q(req_at_tmr)
  );

  always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
    if (!tmr_rst_n) begin
      ack_q    <= 1'b0;
      tmr_val  <= '0;
      tmr_load <= 1'b0;
    end else if (tmr_run && (req_at_tmr != ack_q)) begin
      tmr_val  <= bus_val;
      ack_q    <= req_at_tmr;
      tmr_load <= 1'b1;
    end else begin
      tmr_load <= 1'b0;
    end
  end
endmodule

// File: rtl/txb_clock_switch.sv
module txb_clock_switch #(
  parameter int STAGES = 2
) (
  input  logic bus_clk,
  input  logic bus_rst_n,
  input  logic setup_wr,
  input  logic sel_in,
  output logic armed,
  output logic clk_sel,
  input  logic tmr_clk,
  input  logic tmr_rst_n,
  output logic tmr_run
);
  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      armed   <= 1'b0;
      clk_sel <= 1'b0;
    end else if (setup_wr && !armed) begin
      armed   <= 1'b1;
      clk_sel <= sel_in;
    end
  end

  // The enable synchronizer is the only timer-side logic running before the switch.
  txb_sync #(.W(1), .STAGES(STAGES)) u_run_sync (
    .clk(tmr_clk), .rst_n(tmr_rst_n), .en(1'b1), .d(armed), .q(tmr_run)
  );
endmodule

// File: rtl/timer_xfer_bridge.sv
module timer_xfer_bridge
  import timer_xfer_pkg::*;
#(
  parameter int DW         = 16,
  parameter int STAGES     = 2,
  parameter int CLKSEL_BIT = 12
) (
  input  logic            bus_clk,
  input  logic            bus_rst_n,
  input  logic            tmr_clk,
  input  logic            tmr_rst_n,
  input  logic            bus_valid,
  output logic            bus_ready,
  input  logic            bus_write,
  input  logic [1:0]      bus_size,
  input  logic [IDXW-1:0] bus_addr,
  input  logic [2*DW-1:0] bus_wdata,
  output logic [2*DW-1:0] bus_rdata,
  output logic [1:0]      bus_cmp,
  output logic            tmr_clk_en,
  output logic            tmr_clk_sel,
  output logic [DW-1:0]   tmr_count,
  output logic [DW-1:0]   tmr_cmp1,
  output logic [DW-1:0]   tmr_cmp2,
  output logic [DW-1:0]   tmr_setup,
  output logic [NREG-1:0] tmr_load,
  input  logic [1:0]      tmr_cmp_raw
);
  logic [NREG-1:0] tgt, busy, wr_en;
  logic [DW-1:0]   wr_data [NREG];
  logic [DW-1:0]   bus_val [NREG];
  logic [DW-1:0]   tmr_val [NREG];
  logic            narrow_wr, accept, armed;

  assign tgt       = target_mask(bus_size, bus_addr);
  assign narrow_wr = bus_write && is_narrow(bus_size);
  assign bus_ready = narrow_wr || ((tgt & busy) == '0);
  assign accept    = bus_valid && bus_ready;

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      assign wr_en[r]   = accept && bus_write && !narrow_wr && tgt[r];
      assign wr_data[r] = ((bus_size == SZ_DWORD) && (r % 2 == 1))
                          ? bus_wdata[2*DW-1:DW] : bus_wdata[DW-1:0];

      txb_channel #(.DW(DW), .STAGES(STAGES)) u_chan (
        .bus_clk  (bus_clk),
        .bus_rst_n(bus_rst_n),
        .wr_en    (wr_en[r]),
        .wr_data  (wr_data[r]),
        .bus_val  (bus_val[r]),
        .busy     (busy[r]),
        .tmr_clk  (tmr_clk),
        .tmr_rst_n(tmr_rst_n),
        .tmr_run  (tmr_clk_en),
        .tmr_val  (tmr_val[r]),
        .tmr_load (tmr_load[r])
      );
    end

    for (genvar c = 0; c < 2; c++) begin : g_cmp
      txb_sync #(.W(1), .STAGES(STAGES)) u_cmp_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .en(1'b1),
        .d(tmr_cmp_raw[c]), .q(bus_cmp[c])
      );
    end
  endgenerate

  always_comb begin
    if (bus_size == SZ_DWORD)
      bus_rdata = {bus_val[{bus_addr[1], 1'b1}], bus_val[{bus_addr[1], 1'b0}]};
    else
      bus_rdata = {{DW{1'b0}}, bus_val[bus_addr]};
  end

  txb_clock_switch #(.STAGES(STAGES)) u_switch (
    .bus_clk  (bus_clk),
    .bus_rst_n(bus_rst_n),
    .setup_wr (wr_en[REG_SETUP]),
    .sel_in   (wr_data[REG_SETUP][CLKSEL_BIT]),
    .armed    (armed),
    .clk_sel  (tmr_clk_sel),
    .tmr_clk  (tmr_clk),
    .tmr_rst_n(tmr_rst_n),
    .tmr_run  (tmr_clk_en)
  );

  assign tmr_count = tmr_val[REG_COUNT];
  assign tmr_cmp1  = tmr_val[REG_CMP1];
  assign tmr_cmp2  = tmr_val[REG_CMP2];
  assign tmr_setup = tmr_val[REG_SETUP];
endmodule

// File: rtl/timer_xfer_bridge_checker.sv
module timer_xfer_bridge_checker
  import timer_xfer_pkg::*;
#(
  parameter int DW = 16
) (
  input logic            bus_clk,
  input logic            bus_rst_n,
  input logic            tmr_clk,
  input logic            tmr_rst_n,
  input logic            bus_valid,
  input logic            bus_ready,
  input logic            bus_write,
  input logic [1:0]      bus_size,
  input logic [IDXW-1:0] bus_addr,
  input logic            armed,
  input logic            tmr_clk_en,
  input logic            tmr_clk_sel,
  input logic [NREG-1:0] tmr_load,
  input logic [DW-1:0]   r0,
  input logic [DW-1:0]   r1,
  input logic [DW-1:0]   r2,
  input logic [DW-1:0]   r3
);
  logic            acc;
  logic [NREG-1:0] tmask;
  assign acc   = bus_valid && bus_ready;
  assign tmask = target_mask(bus_size, bus_addr);

  // R4: a register written in one cycle cannot be accepted again in the next.
  assert_no_back_to_back_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (acc && bus_write && !is_narrow(bus_size)) |=>
      !(bus_valid && bus_ready && ((tmask & $past(tmask)) != '0)));

  // R2: narrow writes leave every register as it was.
  assert_byte_write_ignored_R2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (acc && bus_write && is_narrow(bus_size)) |=>
      ($stable(r0) && $stable(r1) && $stable(r2) && $stable(r3)));

  // R6: the clock choice never moves once the switch is armed.
  assert_clk_sel_locked_R6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    armed |=> $stable(tmr_clk_sel));

  // R5: no clock enable before the switch is armed.
  assert_clk_off_before_setup_R5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !armed |-> !tmr_clk_en);

  // R5, R8: no load strobe while the timer clock is off.
  assert_no_load_without_clock_R5: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    (tmr_load != '0) |-> tmr_clk_en);

  // R8: at most... each strobe lasts exactly one timer cycle.
  assert_load_single_cycle_R8: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
    (tmr_load != '0) |=> ((tmr_load & $past(tmr_load)) == '0));
endmodule

bind timer_xfer_bridge timer_xfer_bridge_checker #(.DW(DW)) u_checker (
  .bus_clk    (bus_clk),
  .bus_rst_n  (bus_rst_n),
  .tmr_clk    (tmr_clk),
  .tmr_rst_n  (tmr_rst_n),
  .bus_valid  (bus_valid),
  .bus_ready  (bus_ready),
  .bus_write  (bus_write),
  .bus_size   (bus_size),
  .bus_addr   (bus_addr),
  .armed      (armed),
  .tmr_clk_en (tmr_clk_en),
  .tmr_clk_sel(tmr_clk_sel),
  .tmr_load   (tmr_load),
  .r0         (bus_val[0]),
  .r1         (bus_val[1]),
  .r2         (bus_val[2]),
  .r3         (bus_val[3])
);

// File: tb/timer_xfer_bridge_test.sv
module timer_xfer_bridge_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        bus_clk = 1'b0, tmr_clk = 1'b0;
  logic        bus_rst_n = 1'b0, tmr_rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_size = 2'b10, bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  tmr_cmp_raw = 2'b00;
  logic        bus_ready, tmr_clk_en, tmr_clk_sel;
  logic [31:0] bus_rdata;
  logic [1:0]  bus_cmp;
  logic [15:0] tmr_count, tmr_cmp1, tmr_cmp2, tmr_setup;
  logic [3:0]  tmr_load;

  int checks = 0;
  int errors = 0;

  always #2 bus_clk = ~bus_clk;
  always #5 tmr_clk = ~tmr_clk;

  timer_xfer_bridge uut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_cmp(bus_cmp), .tmr_clk_en(tmr_clk_en),
    .tmr_clk_sel(tmr_clk_sel), .tmr_count(tmr_count), .tmr_cmp1(tmr_cmp1),
    .tmr_cmp2(tmr_cmp2), .tmr_setup(tmr_setup), .tmr_load(tmr_load),
    .tmr_cmp_raw(tmr_cmp_raw)
  );

  // Load monitor, sampled away from the timer clock edge.
  int         load_cnt [4];
  logic [3:0] first_mask;
  logic       seen_load;

  task automatic clear_loads();
    for (int i = 0; i < 4; i++) load_cnt[i] = 0;
    first_mask = '0;
    seen_load  = 1'b0;
  endtask

  always @(negedge tmr_clk) begin
    if (tmr_load != '0) begin
      for (int i = 0; i < 4; i++) if (tmr_load[i]) load_cnt[i]++;
      if (!seen_load) begin
        first_mask = tmr_load;
        seen_load  = 1'b1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_access(input logic wr, input logic [1:0] sz, input logic [1:0] ad,
                            input logic [31:0] wd, input int max_wait,
                            output logic ok, output logic [31:0] rd, output int waits);
    @(negedge bus_clk);
    bus_valid = 1'b1; bus_write = wr; bus_size = sz; bus_addr = ad; bus_wdata = wd;
    ok = 1'b0; rd = '0; waits = 0;
    forever begin
      #1;
      if (bus_ready) begin
        ok = 1'b1;
        rd = bus_rdata;
        break;
      end
      if (waits >= max_wait) break;
      waits++;
      @(negedge bus_clk);
    end
    if (ok) @(negedge bus_clk);
    bus_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (60) @(negedge bus_clk);
  endtask

  task automatic t_reset();
    logic ok; logic [31:0] rd; int w;
    check("R5 clk_en after reset", 32'(tmr_clk_en), 32'd0);
    check("R5 no load after reset", 32'(tmr_load), 32'd0);
    check("R9 cmp after reset", 32'(bus_cmp), 32'd0);
    check("R8 count shadow reset", 32'(tmr_count), 32'd0);
    bus_access(1'b0, 2'b10, 2'd0, '0, 10, ok, rd, w);
    check("R11 idle read ready", 32'(ok), 32'd1);
    check("R11 reset read value", rd, 32'd0);
  endtask

  task automatic t_byte_ignored();
    logic ok; logic [31:0] rd; int w;
    bus_access(1'b1, 2'b01, 2'd1, 32'h0000_BEEF, 10, ok, rd, w);
    check("R2 byte write no wait", 32'(w), 32'd0);
    bus_access(1'b1, 2'b00, 2'd2, 32'h0000_1234, 10, ok, rd, w);
    check("R2 byte0 write no wait", 32'(w), 32'd0);
    bus_access(1'b0, 2'b10, 2'd1, '0, 10, ok, rd, w);
    check("R2 cmp1 not busy after byte write", 32'(ok), 32'd1);
    check("R2 cmp1 unchanged", rd, 32'd0);
    bus_access(1'b0, 2'b10, 2'd2, '0, 10, ok, rd, w);
    check("R2 cmp2 unchanged", rd, 32'd0);
  endtask

  task automatic t_prestart_hang();
    logic ok; logic [31:0] rd; int w;
    bus_access(1'b1, 2'b11, 2'd0, 32'h2222_1111, 10, ok, rd, w);
    check("R3 dword write accepted at once", 32'(w), 32'd0);
    bus_access(1'b0, 2'b10, 2'd0, '0, 300, ok, rd, w);
    check("R10 counter read hangs without clock", 32'(ok), 32'd0);
    bus_access(1'b1, 2'b10, 2'd1, 32'h0000_5555, 100, ok, rd, w);
    check("R10 cmp1 write hangs without clock", 32'(ok), 32'd0);
    bus_access(1'b0, 2'b10, 2'd2, '0, 10, ok, rd, w);
    check("R4 other register unaffected", 32'(ok), 32'd1);
    check("R5 clock still off", 32'(tmr_clk_en), 32'd0);
    check("R5 no loads before setup", 32'(load_cnt[0] + load_cnt[1] + load_cnt[2] + load_cnt[3]), 32'd0);
  endtask

  task automatic t_clock_start();
    logic ok; logic [31:0] rd; int w;
    bus_access(1'b1, 2'b10, 2'd3, 32'h0000_1005, 10, ok, rd, w);
    check("R1 setup write accepted", 32'(w), 32'd0);
    settle();
    check("R5 clock enabled", 32'(tmr_clk_en), 32'd1);
    check("R6 clock select latched", 32'(tmr_clk_sel), 32'd1);
    check("R7 joint load mask", 32'(first_mask), 32'b1011);
    check("R3 counter low half", 32'(tmr_count), 32'h1111);
    check("R3 cmp1 high half", 32'(tmr_cmp1), 32'h2222);
    check("R8 setup value", 32'(tmr_setup), 32'h1005);
    bus_access(1'b0, 2'b10, 2'd0, '0, 10, ok, rd, w);
    check("R4 counter free after ack", 32'(ok), 32'd1);
    check("R11 counter read", rd, 32'h1111);
    bus_access(1'b0, 2'b11, 2'd0, '0, 10, ok, rd, w);
    check("R11 dword read pair", rd, 32'h2222_1111);
  endtask

  task automatic t_sel_lock();
    logic ok; logic [31:0] rd; int w;
    clear_loads();
    bus_access(1'b1, 2'b10, 2'd3, 32'h0000_0007, 10, ok, rd, w);
    settle();
    check("R6 later setup leaves select", 32'(tmr_clk_sel), 32'd1);
    check("R8 setup reload", 32'(tmr_setup), 32'h0007);
    check("R8 one setup strobe", 32'(load_cnt[3]), 32'd1);
  endtask

  task automatic t_back_to_back();
    logic ok; logic [31:0] rd; int w;
    clear_loads();
    bus_access(1'b1, 2'b10, 2'd2, 32'h0000_AAAA, 10, ok, rd, w);
    check("R1 word write no wait", 32'(w), 32'd0);
    bus_access(1'b1, 2'b10, 2'd0, 32'h0000_3333, 10, ok, rd, w);
    check("R4 different register no wait", 32'(w), 32'd0);
    bus_access(1'b1, 2'b10, 2'd2, 32'h0000_BBBB, 200, ok, rd, w);
    check("R4 repeat write completes", 32'(ok), 32'd1);
    check("R4 repeat write stalled", 32'(w > 0), 32'd1);
    settle();
    check("R8 cmp2 final value", 32'(tmr_cmp2), 32'hBBBB);
    check("R8 cmp2 two strobes", 32'(load_cnt[2]), 32'd2);
    check("R8 counter one strobe", 32'(load_cnt[0]), 32'd1);
    check("R8 counter value", 32'(tmr_count), 32'h3333);
  endtask

  task automatic t_cmp_sync();
    @(negedge bus_clk);
    tmr_cmp_raw = 2'b01;
    @(negedge bus_clk);
    check("R9 cmp1 not yet after one edge", 32'(bus_cmp), 32'b00);
    @(negedge bus_clk);
    check("R9 cmp1 after two edges", 32'(bus_cmp), 32'b01);
    tmr_cmp_raw = 2'b11;
    @(negedge bus_clk);
    @(negedge bus_clk);
    check("R9 both compares", 32'(bus_cmp), 32'b11);
    tmr_cmp_raw = 2'b10;
    @(negedge bus_clk);
    @(negedge bus_clk);
    check("R9 cmp1 falls independently", 32'(bus_cmp), 32'b10);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_loads();
    repeat (4) @(negedge bus_clk);
    bus_rst_n = 1'b1;
    tmr_rst_n = 1'b1;
    repeat (2) @(negedge bus_clk);
    t_reset();
    t_byte_ignored();
    t_prestart_hang();
    t_clock_start();
    t_sel_lock();
    t_back_to_back();
    t_cmp_sync();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule